// File: doc/BRIEF.md
# Trigger Throttle Occupancy Tracker

This block keeps a running model of how many event buffers are occupied in a remote front-end chip whose buffer is too far away to report its own fill level in time. Every accepted trigger adds an event, every frame the chip sends out removes one, and a reset pulse empties the model. From the modelled occupancy the block raises a warn level and then a busy level, so that the trigger source can hold off new triggers before the real buffer overflows. Both levels are set as the number of free slots that may remain before they assert.

The busy and warn levels are combinational from the count register. A trigger seen at one clock edge therefore shows up on busy right after that edge, with no extra stage in between. This matters because triggers may arrive only a few clocks apart, while a buffer drains only after thousands of nanoseconds. The block also merges four externally supplied status lines (error, busy, warn, out-of-sync) into its outputs, so the trigger source sees a single set of status lines.

The counter runs a three-state fill machine: EMPTY, PARTIAL and FULL. The transitions are named as follows. Fill (EMPTY to PARTIAL on a trigger). Top (PARTIAL to FULL on the trigger that reaches capacity). Drain (PARTIAL to EMPTY on the frame that removes the last event). Release (FULL to PARTIAL on a frame). Clear (any state to EMPTY on the reset pulse). Every other case holds the state.

Top module: `trig_throttle`

## Requirements
- R1: A reset pulse (`clr_i`) clears the count and both sticky flags on the next edge, even when a trigger or frame pulse arrives in the same cycle.
- R2: A trigger pulse alone raises the count by one on the next edge.
- R3: A frame pulse alone lowers the count by one on the next edge.
- R4: A trigger and a frame pulse in the same cycle leave the count unchanged.
- R5: The count never exceeds CAP (default 10). A trigger at CAP leaves the count at CAP and sets `ovf_o`. `ovf_o` stays set until a reset.
- R6: The count never goes below zero. A frame at zero leaves it at zero and sets `udf_o`. `udf_o` stays set until a reset.
- R7: `busy_o` is high whenever the number of free slots (CAP minus count) is at most `busy_free_i`. It is visible in the cycle right after the trigger edge that causes it, and it drops as soon as a frame frees a slot above the threshold.
- R8: `warn_o` is high whenever the free slots are at most `warn_free_i`, and also whenever busy is high.
- R9: `busy_o`, `warn_o`, `err_o` and `oos_o` are the OR of the internal levels with `ext_busy_i`, `ext_warn_i`, `ext_err_i` and `ext_oos_i`. `ready_o` is high exactly when neither `busy_o` nor `err_o` is high.
- R10: While `rst_n` is low, the count is 0, both flags are 0 and the fill state is EMPTY.
- R11: `fill_o` reports the fill state as 0 = EMPTY (count 0), 1 = PARTIAL (count between 1 and CAP-1) and 2 = FULL (count CAP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Single-cycle trigger pulse |
| frame_i | input | 1 | Single-cycle frame-output pulse |
| clr_i | input | 1 | Single-cycle reset pulse sent to the remote chip |
| warn_free_i | input | CNT_W | Free-slot count at or below which warn asserts |
| busy_free_i | input | CNT_W | Free-slot count at or below which busy asserts |
| ext_err_i | input | 1 | External error status |
| ext_busy_i | input | 1 | External busy status |
| ext_warn_i | input | 1 | External warn status |
| ext_oos_i | input | 1 | External out-of-sync status |
| count_o | output | CNT_W | Modelled occupancy |
| fill_o | output | 2 | Fill state (0 empty, 1 partial, 2 full) |
| busy_o | output | 1 | Merged busy |
| warn_o | output | 1 | Merged warn |
| err_o | output | 1 | Merged error |
| oos_o | output | 1 | Merged out-of-sync |
| ready_o | output | 1 | Neither busy nor error |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that the trigger, frame and reset pulses are synchronous to `clk` and that the thresholds stay fixed while the count is changing. The bench changes thresholds only while the counter sits idle. It drives every pulse a half period away from the sampling edge, so each pulse is seen at exactly one edge. The overflow and underflow checks deliberately push the count past its limits, because the saturation and sticky-flag properties are written to hold under that abuse as well.

// File: rtl/trig_throttle_pkg.sv
package trig_throttle_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_DEC,
        ACT_CLR
    } act_t;

    typedef enum logic [1:0] {
        ZN_OK,
        ZN_WARN,
        ZN_BUSY
    } zone_t;

    function automatic act_t decode_act(input logic inc, input logic dec, input logic clr);
        if (clr)              return ACT_CLR;
        else if (inc && !dec) return ACT_INC;
        else if (dec && !inc) return ACT_DEC;
        else                  return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tt_occupancy.sv
module tt_occupancy
    import trig_throttle_pkg::*;
#(
    parameter int CAP   = 10,
    parameter int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output fill_t            fill_o,
    output logic             ovf_o,
    output logic             udf_o
);
    localparam logic [CNT_W-1:0] CAP_V  = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(CAP - 1);

    act_t             act;
    fill_t            state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q, ovf_d, udf_q, udf_d;

    assign act = decode_act(inc_i, dec_i, clr_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            udf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ovf_q   <= ovf_d;
            udf_q   <= udf_d;
        end
    end

    // Transitions and counter update
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ovf_d   = ovf_q;
        udf_d   = udf_q;
        if (act == ACT_CLR) begin
            state_d = FILL_EMPTY;               // Clear
            cnt_d   = '0;
            ovf_d   = 1'b0;
            udf_d   = 1'b0;
        end else begin
            unique case (state_q)
                FILL_EMPTY: begin
                    if (act == ACT_INC) begin
                        cnt_d   = cnt_q + 1'b1;
                        state_d = (CAP == 1) ? FILL_FULL : FILL_PART;   // Fill
                    end else if (act == ACT_DEC) begin
                        udf_d = 1'b1;
                    end
                end
                FILL_PART: begin
                    if (act == ACT_INC) begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == LAST_V) state_d = FILL_FULL;       // Top
                    end else if (act == ACT_DEC) begin
                        cnt_d = cnt_q - 1'b1;
                        if (cnt_q == 1) state_d = FILL_EMPTY;           // Drain
                    end
                end
                FILL_FULL: begin
                    if (act == ACT_INC) begin
                        ovf_d = 1'b1;
                    end else if (act == ACT_DEC) begin
                        cnt_d   = cnt_q - 1'b1;
                        state_d = (CAP == 1) ? FILL_EMPTY : FILL_PART;  // Release
                    end
                end
                default: state_d = FILL_EMPTY;
            endcase
        end
    end

    // Outputs
    always_comb begin
        count_o = cnt_q;
        fill_o  = state_q;
        ovf_o   = ovf_q;
        udf_o   = udf_q;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0) && !ovf_o && !udf_o);
    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && !clr_i && count_o != CAP_V) |=> count_o == $past(count_o) + 1'b1);
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && !clr_i && count_o != '0) |=> count_o == $past(count_o) - 1'b1);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i && !clr_i) |=> $stable(count_o));
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CAP_V);
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);
    p_udf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_o && !clr_i) |=> udf_o);
    p_udf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && !clr_i && count_o == '0) |=> udf_o && count_o == '0);
    p_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == FILL_EMPTY) == (count_o == '0));

endmodule

// File: rtl/tt_zone.sv
module tt_zone
    import trig_throttle_pkg::*;
#(
    parameter int CAP   = 10,
    parameter int CNT_W = $clog2(CAP + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] warn_free_i,
    input  logic [CNT_W-1:0] busy_free_i,
    output zone_t            zone_o
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    logic [CNT_W-1:0] free_slots;
    logic             busy_hit, warn_hit;

    always_comb begin
        free_slots = CAP_V - count_i;
        busy_hit   = (free_slots <= busy_free_i);
        warn_hit   = (free_slots <= warn_free_i);
        if (busy_hit)      zone_o = ZN_BUSY;
        else if (warn_hit) zone_o = ZN_WARN;
        else               zone_o = ZN_OK;
    end

endmodule

// File: rtl/tt_merge.sv
module tt_merge
    import trig_throttle_pkg::*;
(
    input  zone_t zone_i,
    input  logic  ext_err_i,
    input  logic  ext_busy_i,
    input  logic  ext_warn_i,
    input  logic  ext_oos_i,
    output logic  busy_o,
    output logic  warn_o,
    output logic  err_o,
    output logic  oos_o,
    output logic  ready_o
);
    always_comb begin
        busy_o  = (zone_i == ZN_BUSY) | ext_busy_i;
        warn_o  = (zone_i != ZN_OK) | ext_warn_i | busy_o;
        err_o   = ext_err_i;
        oos_o   = ext_oos_i;
        ready_o = !(busy_o | err_o);
    end

endmodule

// File: rtl/trig_throttle.sv
module trig_throttle
    import trig_throttle_pkg::*;
#(
    parameter int CAP   = 10,
    parameter int CNT_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             frame_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] warn_free_i,
    input  logic [CNT_W-1:0] busy_free_i,
    input  logic             ext_err_i,
    input  logic             ext_busy_i,
    input  logic             ext_warn_i,
    input  logic             ext_oos_i,
    output logic [CNT_W-1:0] count_o,
    output logic [1:0]       fill_o,
    output logic             busy_o,
    output logic             warn_o,
    output logic             err_o,
    output logic             oos_o,
    output logic             ready_o,
    output logic             ovf_o,
    output logic             udf_o
);
    fill_t fill_s;
    zone_t zone_s;

    tt_occupancy #(.CAP(CAP), .CNT_W(CNT_W)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (trig_i),
        .dec_i   (frame_i),
        .clr_i   (clr_i),
        .count_o (count_o),
        .fill_o  (fill_s),
        .ovf_o   (ovf_o),
        .udf_o   (udf_o)
    );

    tt_zone #(.CAP(CAP), .CNT_W(CNT_W)) u_zone (
        .count_i     (count_o),
        .warn_free_i (warn_free_i),
        .busy_free_i (busy_free_i),
        .zone_o      (zone_s)
    );

    tt_merge u_merge (
        .zone_i     (zone_s),
        .ext_err_i  (ext_err_i),
        .ext_busy_i (ext_busy_i),
        .ext_warn_i (ext_warn_i),
        .ext_oos_i  (ext_oos_i),
        .busy_o     (busy_o),
        .warn_o     (warn_o),
        .err_o      (err_o),
        .oos_o      (oos_o),
        .ready_o    (ready_o)
    );

    assign fill_o = fill_s;

    p_warn_covers_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> warn_o);
    p_ext_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_busy_i |-> busy_o) and (ext_warn_i |-> warn_o) and
        (ext_err_i |-> err_o) and (ext_oos_i |-> oos_o));
    p_busy_at_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == 2'd2 && busy_free_i != '0) |-> busy_o);

endmodule

// File: tb/trig_throttle_tb.sv
module trig_throttle_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CAP   = 10;
    localparam int CNT_W = $clog2(CAP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_i = 1'b0, frame_i = 1'b0, clr_i = 1'b0;
    logic [CNT_W-1:0] warn_free_i = CNT_W'(5);
    logic [CNT_W-1:0] busy_free_i = CNT_W'(2);
    logic ext_err_i = 1'b0, ext_busy_i = 1'b0, ext_warn_i = 1'b0, ext_oos_i = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic [1:0] fill_o;
    logic busy_o, warn_o, err_o, oos_o, ready_o, ovf_o, udf_o;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_throttle #(.CAP(CAP), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .frame_i(frame_i), .clr_i(clr_i),
        .warn_free_i(warn_free_i), .busy_free_i(busy_free_i),
        .ext_err_i(ext_err_i), .ext_busy_i(ext_busy_i), .ext_warn_i(ext_warn_i),
        .ext_oos_i(ext_oos_i), .count_o(count_o), .fill_o(fill_o), .busy_o(busy_o),
        .warn_o(warn_o), .err_o(err_o), .oos_o(oos_o), .ready_o(ready_o),
        .ovf_o(ovf_o), .udf_o(udf_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One-cycle stimulus, applied and removed on falling edges
    task automatic pulse(input logic t, input logic f, input logic c);
        @(negedge clk);
        trig_i = t; frame_i = f; clr_i = c;
        @(negedge clk);
        trig_i = 0; frame_i = 0; clr_i = 0;
        #1;
    endtask

    function automatic int exp_busy();
        return ((CAP - exp_cnt) <= int'(busy_free_i)) ? 1 : 0;
    endfunction
    function automatic int exp_warn();
        return (((CAP - exp_cnt) <= int'(warn_free_i)) || exp_busy() == 1) ? 1 : 0;
    endfunction
    function automatic int exp_fill();
        return (exp_cnt == 0) ? 0 : (exp_cnt == CAP) ? 2 : 1;
    endfunction

    task automatic check_levels(input string tag);
        chk("R7", {tag, " busy"}, int'(busy_o), exp_busy());
        chk("R8", {tag, " warn"}, int'(warn_o), exp_warn());
    endtask

    task automatic t_reset();
        #1;
        chk("R10", "count in reset", int'(count_o), 0);
        chk("R10", "ovf in reset", int'(ovf_o), 0);
        chk("R10", "fill in reset", int'(fill_o), 0);
        @(negedge clk); rst_n = 1'b1; #1;
    endtask

    task automatic t_fill_up();
        for (int i = 1; i <= 8; i++) begin
            pulse(1, 0, 0); exp_cnt++;
            chk("R2", "count after trigger", int'(count_o), exp_cnt);
            check_levels("fill");
            chk("R11", "fill partial", int'(fill_o), exp_fill());
        end
        chk("R7", "busy at 8", int'(busy_o), 1);
    endtask

    task automatic t_drain();
        pulse(0, 1, 0); exp_cnt--;
        chk("R3", "count after frame", int'(count_o), exp_cnt);
        chk("R7", "busy released", int'(busy_o), 0);
        chk("R8", "warn kept", int'(warn_o), 1);
        pulse(1, 0, 0); exp_cnt++;
        chk("R7", "busy reasserted", int'(busy_o), 1);
    endtask

    task automatic t_simul();
        pulse(1, 1, 0);
        chk("R4", "hold on both", int'(count_o), exp_cnt);
    endtask

    task automatic t_overflow();
        while (exp_cnt < CAP) begin pulse(1, 0, 0); exp_cnt++; end
        chk("R11", "fill full", int'(fill_o), 2);
        pulse(1, 0, 0);
        chk("R5", "count saturates", int'(count_o), CAP);
        chk("R5", "ovf set", int'(ovf_o), 1);
        pulse(0, 1, 0); exp_cnt--;
        chk("R5", "ovf sticky", int'(ovf_o), 1);
        chk("R11", "fill release", int'(fill_o), 1);
    endtask

    task automatic t_clear_priority();
        pulse(1, 0, 1); exp_cnt = 0;
        chk("R1", "clear beats trigger", int'(count_o), 0);
        chk("R1", "ovf cleared", int'(ovf_o), 0);
        chk("R11", "fill empty", int'(fill_o), 0);
        check_levels("cleared");
    endtask

    task automatic t_underflow();
        pulse(0, 1, 0);
        chk("R6", "count stays zero", int'(count_o), 0);
        chk("R6", "udf set", int'(udf_o), 1);
        pulse(1, 0, 0); exp_cnt++;
        chk("R6", "udf sticky", int'(udf_o), 1);
        pulse(0, 1, 1); exp_cnt = 0;
        chk("R1", "udf cleared", int'(udf_o), 0);
        chk("R1", "clear beats frame", int'(count_o), 0);
    endtask

    task automatic t_program();
        warn_free_i = CNT_W'(1); busy_free_i = CNT_W'(4);
        for (int i = 0; i < 6; i++) begin
            pulse(1, 0, 0); exp_cnt++;
            check_levels("prog");
        end
        chk("R8", "warn forced by busy", int'(warn_o), 1);
        pulse(1, 0, 1); exp_cnt = 0;
        warn_free_i = CNT_W'(5); busy_free_i = CNT_W'(2);
        #1;
    endtask

    task automatic t_external();
        #1;
        chk("R9", "ready idle", int'(ready_o), 1);
        ext_busy_i = 1'b1; #1;
        chk("R9", "ext busy", int'(busy_o), 1);
        chk("R9", "ready low on busy", int'(ready_o), 0);
        ext_busy_i = 1'b0; ext_warn_i = 1'b1; #1;
        chk("R9", "ext warn", int'(warn_o), 1);
        chk("R9", "busy not from warn", int'(busy_o), 0);
        ext_warn_i = 1'b0; ext_err_i = 1'b1; #1;
        chk("R9", "ext err", int'(err_o), 1);
        chk("R9", "ready low on err", int'(ready_o), 0);
        ext_err_i = 1'b0; ext_oos_i = 1'b1; #1;
        chk("R9", "ext oos", int'(oos_o), 1);
        chk("R9", "ready with oos", int'(ready_o), 1);
        ext_oos_i = 1'b0; #1;
        chk("R9", "oos cleared", int'(oos_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_up();
        t_drain();
        t_simul();
        t_overflow();
        t_clear_priority();
        t_underflow();
        t_program();
        t_external();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule